// File: doc/BRIEF.md
# Serial-Bus Tuner Register Slave

This block is the two-wire serial slave that holds the tuning registers of a frequency synthesizer. It oversamples the bus clock (SCL) and data (SDA) lines with the system clock through two-flop synchronizers. It detects START and STOP conditions and answers one 7-bit device address. The two low bits of that address come from a pair of select pins, so four synthesizers can share a bus.

In a write transfer, the block sorts the incoming data bytes by their most significant bit. A byte with MSB 0 opens a two-byte divider pair. A byte with MSB 1 is either a control byte or a band byte, and which one it is depends on the byte before it. Bytes keep streaming without a new address until STOP, so a host can sweep the frequency in one transfer.

In a read transfer, the block returns a status byte. That byte carries a sticky power-on flag, the loop-lock input and a 3-bit level code. Driving the open-drain pad and decoding the select pins from analog levels are left to the surrounding logic.

Top module: `tuner_i2c_slave`

## Requirements
- R1: After reset, the divider word, the control fields and the band outputs are all zero, the power-on flag is 1, and `sda_pull` is 0.
- R2: The block acknowledges (drives SDA low in the ninth clock slot) only an address byte whose upper seven bits equal `1100 0` followed by `addr_sel[1]`, `addr_sel[0]`. Bit 0 of the address byte is R/W, with 1 meaning read. On any other address it never drives SDA until the next START, and the bytes that follow change no register.
- R3: A write data byte with bit 7 = 0 begins a divider pair, and its bits 6:0 become N[14:8]. The next data byte supplies N[7:0], whatever its value. The 15-bit `div_word` updates only once both bytes have been received. A pair broken off by STOP or START leaves `div_word` unchanged, and the half pair is discarded at the next addressed write.
- R4: A control byte sets the control fields from its bits: bit 6 to `pump_hi`, bits 5:3 to `test_code`, bits 2:1 to `ref_sel` and bit 0 to `amp_off`.
- R5: A byte with bit 7 = 1 that directly follows a control byte in the same transfer is a band byte. Its bits 3:0 drive `band_out[3:0]`, and its bits 6:4 are ignored.
- R6: Any other byte with bit 7 = 1 is a control byte, including one that follows a band byte, a divider pair or the address.
- R7: Within one write transfer, any number of data bytes may follow without re-addressing, and every completed pair, control byte and band byte takes effect.
- R8: The slave acknowledges every complete data byte of an addressed write.
- R9: In a read, the slave sends MSB first `{por, lock_flag, 1, 1, 1, level_code[2:0]}`. A master ACK causes the status byte to be sent again, and a master NACK ends the transfer.
- R10: The power-on flag drops to 0 after a status byte has been sent in full. A pulse on `pwr_fail` sets it to 1 again.
- R11: A START in the middle of any byte restarts address reception, and the interrupted byte has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_sel | input | 2 | Low two bits of the device address |
| lock_flag | input | 1 | Loop lock indication, reported in status |
| pwr_fail | input | 1 | Sets the sticky power-on flag |
| level_code | input | 3 | Level code reported in status bits 2:0 |
| sda_pull | output | 1 | 1 = drive SDA low |
| div_word | output | 15 | Committed divider word N |
| pump_hi | output | 1 | Charge-pump current select |
| test_code | output | 3 | Test mode code |
| ref_sel | output | 2 | Reference divider select |
| amp_off | output | 1 | Tuning amplifier off |
| band_out | output | 4 | Band switch outputs |

## Verification
The hardest states to reach are the ones where byte history matters. One is a half divider pair left pending by an aborted transfer, which must not swallow the first byte of the next write. Another is a START arriving a few bits into a byte. The bench creates these directly: it sends a lone high byte and then STOP, it breaks off bytes after three bits with a repeated START, and it places control-like bytes after pairs, after band bytes and back to back. Random streams of mixed-MSB bytes then exercise the pair, control and band classification against a bench model built from the rules.

// File: rtl/tnr_pkg.sv
package tnr_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          CNT_W      = $clog2(BYTE_W + 1);
    localparam logic [4:0]  DEV_PREFIX = 5'b11000;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_WDATA,
        LK_WACK,
        LK_RDATA,
        LK_RACK
    } link_state_t;

    typedef struct packed {
        logic       pump_hi;
        logic [2:0] test_code;
        logic [1:0] ref_sel;
        logic       amp_off;
    } ctrl_t;

    function automatic logic addr_hit(input logic [6:0] a, input logic [1:0] sel);
        return a == {DEV_PREFIX, sel};
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic por,
                                                      input logic lock,
                                                      input logic [2:0] lvl);
        return {por, lock, 3'b111, lvl};
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[6:0]);
    endfunction

endpackage

// File: rtl/tnr_sync.sv
module tnr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/tnr_link.sv
module tnr_link
    import tnr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] status,
    output logic              sda_pull,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              wr_begin,
    output logic              status_read
);
    link_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx, tx;
    logic              rd_mode, mack, scl_d, sda_d;

    wire scl_rise   = scl_s & ~scl_d;
    wire scl_fall   = ~scl_s & scl_d;
    wire start_cond = scl_s & scl_d & sda_d & ~sda_s;
    wire stop_cond  = scl_s & scl_d & ~sda_d & sda_s;
    wire full_byte  = (bit_cnt == CNT_W'(BYTE_W));

    assign byte_data = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= LK_IDLE;
            bit_cnt     <= '0;
            rx          <= '0;
            tx          <= '0;
            sda_pull    <= 1'b0;
            rd_mode     <= 1'b0;
            mack        <= 1'b1;
            byte_valid  <= 1'b0;
            wr_begin    <= 1'b0;
            status_read <= 1'b0;
        end else begin
            byte_valid  <= 1'b0;
            wr_begin    <= 1'b0;
            status_read <= 1'b0;
            if (start_cond) begin
                state    <= LK_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_cond) begin
                state    <= LK_IDLE;
                sda_pull <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    LK_ADDR, LK_WDATA: begin
                        rx      <= {rx[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    LK_RDATA: bit_cnt <= bit_cnt + 1'b1;
                    LK_RACK:  mack    <= sda_s;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    LK_ADDR: if (full_byte) begin
                        if (addr_hit(rx[7:1], addr_sel)) begin
                            state    <= LK_ADDR_ACK;
                            sda_pull <= 1'b1;
                            rd_mode  <= rx[0];
                        end else begin
                            state <= LK_IDLE;
                        end
                    end
                    LK_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            state    <= LK_RDATA;
                            sda_pull <= ~status[BYTE_W-1];
                            tx       <= {status[BYTE_W-2:0], 1'b0};
                        end else begin
                            state    <= LK_WDATA;
                            sda_pull <= 1'b0;
                            wr_begin <= 1'b1;
                        end
                    end
                    LK_WDATA: if (full_byte) begin
                        state      <= LK_WACK;
                        sda_pull   <= 1'b1;
                        byte_valid <= 1'b1;
                    end
                    LK_WACK: begin
                        state    <= LK_WDATA;
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                    end
                    LK_RDATA: begin
                        if (full_byte) begin
                            state       <= LK_RACK;
                            sda_pull    <= 1'b0;
                            status_read <= 1'b1;
                        end else begin
                            sda_pull <= ~tx[BYTE_W-1];
                            tx       <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                    LK_RACK: begin
                        if (!mack) begin
                            state    <= LK_RDATA;
                            bit_cnt  <= '0;
                            sda_pull <= ~status[BYTE_W-1];
                            tx       <= {status[BYTE_W-2:0], 1'b0};
                        end else begin
                            state <= LK_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: acknowledge slot after a matching address holds SDA low
    a_r2_addr_ack_low: assert property (@(posedge clk) disable iff (rst)
        state == LK_ADDR_ACK |-> sda_pull);
    // R2: an unaddressed slave leaves the line alone
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        state == LK_IDLE |-> !sda_pull);
    // R8: every data acknowledge slot holds SDA low
    a_r8_data_ack_low: assert property (@(posedge clk) disable iff (rst)
        state == LK_WACK |-> sda_pull);
    // R11: a START always returns to address reception with SDA released
    a_r11_start_restart: assert property (@(posedge clk) disable iff (rst)
        start_cond |=> (state == LK_ADDR) && !sda_pull);
    // R10: completion of a status byte is a single pulse
    a_r10_read_pulse: assert property (@(posedge clk) disable iff (rst)
        status_read |=> !status_read);
endmodule

// File: rtl/tnr_regs.sv
module tnr_regs
    import tnr_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              wr_begin,
    input  logic              status_read,
    input  logic              pwr_fail,
    output logic [DIV_W-1:0]  div_word,
    output ctrl_t             ctrl,
    output logic [BAND_W-1:0] band,
    output logic              por_flag
);
    localparam int HI_W = DIV_W - BYTE_W;

    logic            have_hi, after_ctrl;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_hi    <= 1'b0;
            after_ctrl <= 1'b0;
            hi_q       <= '0;
            div_word   <= '0;
            ctrl       <= '0;
            band       <= '0;
            por_flag   <= 1'b1;
        end else begin
            if (pwr_fail)         por_flag <= 1'b1;
            else if (status_read) por_flag <= 1'b0;

            if (wr_begin) begin
                have_hi    <= 1'b0;
                after_ctrl <= 1'b0;
            end else if (byte_valid) begin
                if (have_hi) begin
                    div_word   <= {hi_q, byte_data};
                    have_hi    <= 1'b0;
                    after_ctrl <= 1'b0;
                end else if (!byte_data[BYTE_W-1]) begin
                    hi_q       <= byte_data[HI_W-1:0];
                    have_hi    <= 1'b1;
                    after_ctrl <= 1'b0;
                end else if (after_ctrl) begin
                    band       <= byte_data[BAND_W-1:0];
                    after_ctrl <= 1'b0;
                end else begin
                    ctrl       <= ctrl_decode(byte_data);
                    after_ctrl <= 1'b1;
                end
            end
        end
    end

    // R3: divider word moves only on a received byte
    a_r3_div_hold: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> $stable(div_word));
    // R3: the first byte of a pair never alters the divider word
    a_r3_no_half_commit: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !have_hi) |=> $stable(div_word));
    // R5: band outputs move only on a received byte
    a_r5_band_hold: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> $stable(band));
    // R10: a completed status read clears the flag unless a new power event arrives
    a_r10_por_clear: assert property (@(posedge clk) disable iff (rst)
        (status_read && !pwr_fail) |=> !por_flag);
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
    import tnr_pkg::*;
#(
    parameter int DIV_W       = 15,
    parameter int BAND_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [1:0]        addr_sel,
    input  logic              lock_flag,
    input  logic              pwr_fail,
    input  logic [2:0]        level_code,
    output logic              sda_pull,
    output logic [DIV_W-1:0]  div_word,
    output logic              pump_hi,
    output logic [2:0]        test_code,
    output logic [1:0]        ref_sel,
    output logic              amp_off,
    output logic [BAND_W-1:0] band_out
);
    logic [1:0]        line_s;
    logic              byte_valid, wr_begin, status_read, por_flag;
    logic [BYTE_W-1:0] byte_data, status;
    ctrl_t             ctrl;

    tnr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (line_s)
    );

    assign status = status_byte(por_flag, lock_flag, level_code);

    tnr_link u_link (
        .clk         (clk),
        .rst         (rst),
        .scl_s       (line_s[1]),
        .sda_s       (line_s[0]),
        .addr_sel    (addr_sel),
        .status      (status),
        .sda_pull    (sda_pull),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .wr_begin    (wr_begin),
        .status_read (status_read)
    );

    tnr_regs #(.DIV_W(DIV_W), .BAND_W(BAND_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .wr_begin    (wr_begin),
        .status_read (status_read),
        .pwr_fail    (pwr_fail),
        .div_word    (div_word),
        .ctrl        (ctrl),
        .band        (band_out),
        .por_flag    (por_flag)
    );

    assign pump_hi   = ctrl.pump_hi;
    assign test_code = ctrl.test_code;
    assign ref_sel   = ctrl.ref_sel;
    assign amp_off   = ctrl.amp_off;
endmodule

// File: tb/tuner_i2c_slave_tb.sv
module tuner_i2c_slave_tb;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic lock = 1'b0, pwr_fail = 1'b0;
    logic [2:0] lvl = 3'b000;
    logic sda_pull, pump_hi, amp_off;
    logic [14:0] div_word;
    logic [2:0] test_code;
    logic [1:0] ref_sel;
    logic [3:0] band_out;
    wire sda_line = sda_m & ~sda_pull;

    tuner_i2c_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .lock_flag(lock), .pwr_fail(pwr_fail),
        .level_code(lvl), .sda_pull(sda_pull), .div_word(div_word),
        .pump_hi(pump_hi), .test_code(test_code), .ref_sel(ref_sel),
        .amp_off(amp_off), .band_out(band_out)
    );

    int checks = 0, fails = 0;
    logic [14:0] e_div = '0;
    logic [6:0]  e_ctrl = '0;
    logic [3:0]  e_band = '0;
    logic        e_por = 1'b1;
    logic        m_hi, m_after;
    logic [6:0]  m_hival;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hwait(); scl_m = 1'b1; hwait();
        sda_m = 1'b0; hwait(); scl_m = 1'b0; hwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hwait(); scl_m = 1'b1; hwait(); sda_m = 1'b1; hwait();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; hwait(); scl_m = 1'b1; hwait(); scl_m = 1'b0; hwait();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hwait(); scl_m = 1'b1; hwait(); b = sda_line;
        scl_m = 1'b0; hwait();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~master_ack);
    endtask

    // reference model of byte classification (R3, R5, R6)
    task automatic model_begin();
        m_hi = 1'b0; m_after = 1'b0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_hi) begin
            e_div = {m_hival, b}; m_hi = 1'b0; m_after = 1'b0;
        end else if (!b[7]) begin
            m_hival = b[6:0]; m_hi = 1'b1; m_after = 1'b0;
        end else if (m_after) begin
            e_band = b[3:0]; m_after = 1'b0;
        end else begin
            e_ctrl = b[6:0]; m_after = 1'b1;
        end
    endtask

    task automatic check_regs(input string req);
        chk({req, " div"}, 32'(div_word), 32'(e_div));
        chk({req, " ctrl"}, 32'({pump_hi, test_code, ref_sel, amp_off}), 32'(e_ctrl));
        chk({req, " band"}, 32'(band_out), 32'(e_band));
    endtask

    task automatic write_xfer(input string req, input logic [7:0] bytes[$]);
        logic ack;
        logic all_ack;
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b0}, ack);
        all_ack = ack;
        model_begin();
        foreach (bytes[i]) begin
            put_byte(bytes[i], ack);
            all_ack = all_ack & ack;
            model_byte(bytes[i]);
        end
        bus_stop();
        chk({req, " R8 acks"}, 32'(all_ack), 32'd1);
    endtask

    task automatic read_status(input string req, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b1}, ack);
        chk({req, " R2 read addr ack"}, 32'(ack), 32'd1);
        for (int k = 0; k < n; k++) begin
            get_byte(k != n - 1, v);
            chk({req, " R9 status"}, 32'(v), 32'({e_por, lock, 3'b111, lvl}));
            e_por = 1'b0;
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic ack;
        logic [7:0] q[$];
        int unsigned seed;
        seed = $urandom(32'h00C0FFEE);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        check_regs("R1");
        chk("R1 sda_pull", 32'(sda_pull), 32'd0);

        // R9 read with master ACK then NACK, R10 flag clears
        lock = 1'b1; lvl = 3'b101;
        read_status("R9 R10 first", 2);
        read_status("R10 cleared", 1);

        // R2 wrong address: no ack, data ignored
        addr_sel = 2'b10;
        bus_start();
        put_byte({5'b11000, 2'b01, 1'b0}, ack);
        chk("R2 mismatch no ack", 32'(ack), 32'd0);
        put_byte(8'h12, ack);
        chk("R2 ignored byte no ack", 32'(ack), 32'd0);
        put_byte(8'h34, ack);
        bus_stop();
        check_regs("R2 no effect");

        // R3 full pair
        q = '{8'h2A, 8'hBC};
        write_xfer("R3 pair", q);
        check_regs("R3 pair");

        // R3 half pair then STOP, then control byte in next transfer (R6)
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b0}, ack);
        put_byte(8'h11, ack);
        bus_stop();
        check_regs("R3 half pair");
        q = '{8'hC3};
        write_xfer("R6 after abort", q);
        check_regs("R6 R3 after abort");

        // R4 R5 control then band, upper band bits ignored
        q = '{8'hD5, 8'hF9};
        write_xfer("R4 R5", q);
        check_regs("R4 R5");

        // R6 MSB1 after pair and after band are control bytes
        q = '{8'h01, 8'h02, 8'h8F, 8'hF3, 8'hA2};
        write_xfer("R6 classify", q);
        check_regs("R6 classify");

        // R7 streaming pairs checked inside one transfer
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b0}, ack);
        for (int k = 0; k < 3; k++) begin
            put_byte(8'(k + 8'h30), ack);
            put_byte(8'(8'h40 + k), ack);
            chk("R7 streamed pair", 32'(div_word), 32'({7'(k + 8'h30), 8'(8'h40 + k)}));
        end
        bus_stop();
        e_div = {7'h32, 8'h42};

        // R11 START inside a data byte and inside an address byte
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b0}, ack);
        put_byte(8'h05, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte({5'b11000, addr_sel, 1'b0}, ack);
        chk("R11 addr after restart", 32'(ack), 32'd1);
        put_byte(8'h01, ack);
        put_byte(8'h23, ack);
        bus_stop();
        e_div = 15'h0123;
        check_regs("R11 restart");

        // R10 power event sets the flag again
        @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
        e_por = 1'b1; lock = 1'b0; lvl = 3'b010;
        read_status("R10 re-set", 1);

        // random byte streams
        for (int it = 0; it < 12; it++) begin
            int n;
            addr_sel = 2'($urandom);
            n = 1 + int'($urandom % 6);
            q.delete();
            for (int j = 0; j < n; j++) q.push_back(8'($urandom));
            write_xfer("R3 R5 R6 R7 random", q);
            check_regs("R3 R4 R5 R6 random");
        end
        lvl = 3'($urandom); lock = 1'b1;
        read_status("R9 random", 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule